// File: doc/BRIEF.md
# Windowed PCIe Address Translator

This block holds the address translation windows of a PCIe controller. Eight windows share one indirect register page: four map outgoing local addresses onto bus addresses, and four map incoming BAR hits onto local memory. Software writes a selector register to choose the direction and the window number. The following field offsets then read and write that window's base, limit, target and control words.

Two combinational lookups use the programmed windows. The outgoing lookup takes a 64-bit local address. It returns the translated bus address, the transaction kind of the matching window and a hit flag. The incoming lookup takes a BAR number and an offset inside that BAR. It returns a local address and a hit flag. Packet formation, link training and configuration-space decoding stay outside the block.

Top module: `xlat_window_unit`

## Requirements
- R1: After reset every window is disabled with all fields zero, and the selector reads 0.
- R2: The selector sits at offset 0x900. Bit 31 picks the bank (1 incoming, 0 outgoing) and bits 1:0 pick the window. A read of 0x900 returns the full last written value.
- R3: Field offsets act on the window named by the selector: 0x904 kind (bits 4:0), 0x908 control (bit 31 enable, bit 30 BAR-match, bits 10:8 BAR number), 0x90C base low, 0x910 base high, 0x914 limit, 0x918 target low, 0x91C target high. A read returns that window's stored field. Any other offset reads 0 and ignores writes.
- R4: An enabled outgoing window hits when address bits 63:32 equal base high and bits 31:0 lie from base low through limit inclusive. The result is target + (address − base), with the window's kind.
- R5: An address equal to the limit hits. The limit plus one misses, and so does the base minus one.
- R6: When several enabled outgoing windows hit, the lowest index supplies the result.
- R7: On an outgoing miss the hit flag is low, the bus address equals the input address, and the kind is 0 (memory).
- R8: A disabled window never hits, whatever its fields hold.
- R9: An incoming window hits when it is enabled, its BAR-match bit is set, and its BAR number equals the input BAR. The local address is target + offset, and the lowest index wins. With no hit the flag is low and the local address is 0.
- R10: Writes to one bank leave the other bank's fields and lookups unchanged.
- R11: A configuration window (kind 4 or 5) whose target low holds bus in bits 31:24, device in 23:19 and function in 18:16 places those fields at the same bit positions of the bus address for an address at its base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ofs | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_ofs |
| out_addr | input | 64 | Outgoing local address |
| out_bus_addr | output | 64 | Translated bus address |
| out_kind | output | 5 | Transaction kind of the hit window |
| out_hit | output | 1 | Outgoing window hit |
| in_bar | input | 3 | BAR number of an incoming access |
| in_offset | input | IB_OFS_W | Offset inside that BAR |
| in_local_addr | output | 64 | Translated local address |
| in_hit | output | 1 | Incoming window hit |

## Verification
Outgoing probes fall in several places: inside a single window, in the overlap of two windows, exactly on a limit, one past a limit, one below a base, and at a matching low word with the wrong high word. Together these separate the range comparison, the high-word compare and the index priority. A window that is first disabled and then enabled shows that the enable bit gates matching. Incoming probes target a BAR claimed by two windows, and also a window that is enabled but not in BAR-match mode, which shows that priority and the mode bit both apply. Register readback through both banks shows that the selector routes every field to the right window without disturbing the other bank.

// File: rtl/xw_pkg.sv
package xw_pkg;

    localparam logic [11:0] OFS_VIEW  = 12'h900;
    localparam logic [11:0] OFS_KIND  = 12'h904;
    localparam logic [11:0] OFS_CTRL  = 12'h908;
    localparam logic [11:0] OFS_BASEL = 12'h90C;
    localparam logic [11:0] OFS_BASEH = 12'h910;
    localparam logic [11:0] OFS_LIMIT = 12'h914;
    localparam logic [11:0] OFS_TGTL  = 12'h918;
    localparam logic [11:0] OFS_TGTH  = 12'h91C;

    typedef enum logic [4:0] {
        XW_MEM  = 5'd0,
        XW_IO   = 5'd2,
        XW_CFG0 = 5'd4,
        XW_CFG1 = 5'd5
    } xw_kind_e;

    // stored content of one window
    typedef struct packed {
        logic [31:0] base_lo;
        logic [31:0] base_hi;
        logic [31:0] limit_lo;
        logic [31:0] tgt_lo;
        logic [31:0] tgt_hi;
        logic [4:0]  kind;
        logic        en;
        logic        bar_mode;
        logic [2:0]  bar;
    } xw_region_t;

    // fields the outgoing lookup needs
    typedef struct packed {
        logic [63:0] base;
        logic [31:0] limit_lo;
        logic [63:0] tgt;
        logic [4:0]  kind;
        logic        en;
    } xw_ob_view_t;

    // fields the incoming lookup needs
    typedef struct packed {
        logic [63:0] tgt;
        logic        en;
        logic        bar_mode;
        logic [2:0]  bar;
    } xw_ib_view_t;

endpackage

// File: rtl/xw_window_regs.sv
module xw_window_regs
    import xw_pkg::*;
#(
    parameter int N_WIN = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [11:0]              cfg_ofs,
    input  logic [31:0]              cfg_wdata,
    output logic [31:0]              cfg_rdata,
    output xw_ob_view_t [N_WIN-1:0]  ob_view,
    output xw_ib_view_t [N_WIN-1:0]  ib_view
);
    localparam int IDX_W = (N_WIN > 1) ? $clog2(N_WIN) : 1;

    typedef struct packed {
        logic [31:0]             view;
        xw_region_t [N_WIN-1:0]  ob;
        xw_region_t [N_WIN-1:0]  ib;
    } state_t;

    state_t      s_d, s_q;
    logic [IDX_W-1:0] sel;
    logic        dir_in;
    xw_region_t  cur, upd;
    logic        fld_hit;

    always_comb begin
        s_d     = s_q;
        sel     = s_q.view[IDX_W-1:0];
        dir_in  = s_q.view[31];
        cur     = dir_in ? s_q.ib[sel] : s_q.ob[sel];
        upd     = cur;
        fld_hit = 1'b1;
        case (cfg_ofs)
            OFS_KIND:  upd.kind = cfg_wdata[4:0];
            OFS_CTRL: begin
                upd.en       = cfg_wdata[31];
                upd.bar_mode = cfg_wdata[30];
                upd.bar      = cfg_wdata[10:8];
            end
            OFS_BASEL: upd.base_lo  = cfg_wdata;
            OFS_BASEH: upd.base_hi  = cfg_wdata;
            OFS_LIMIT: upd.limit_lo = cfg_wdata;
            OFS_TGTL:  upd.tgt_lo   = cfg_wdata;
            OFS_TGTH:  upd.tgt_hi   = cfg_wdata;
            default:   fld_hit = 1'b0;
        endcase
        if (cfg_we) begin
            if (cfg_ofs == OFS_VIEW) begin
                s_d.view = cfg_wdata;
            end else if (fld_hit) begin
                if (dir_in) s_d.ib[sel] = upd;
                else        s_d.ob[sel] = upd;
            end
        end
    end

    always_comb begin
        case (cfg_ofs)
            OFS_VIEW:  cfg_rdata = s_q.view;
            OFS_KIND:  cfg_rdata = {27'd0, cur.kind};
            OFS_CTRL:  cfg_rdata = {cur.en, cur.bar_mode, 19'd0, cur.bar, 8'd0};
            OFS_BASEL: cfg_rdata = cur.base_lo;
            OFS_BASEH: cfg_rdata = cur.base_hi;
            OFS_LIMIT: cfg_rdata = cur.limit_lo;
            OFS_TGTL:  cfg_rdata = cur.tgt_lo;
            OFS_TGTH:  cfg_rdata = cur.tgt_hi;
            default:   cfg_rdata = 32'd0;
        endcase
    end

    always_comb begin
        for (int i = 0; i < N_WIN; i++) begin
            ob_view[i].base     = {s_q.ob[i].base_hi, s_q.ob[i].base_lo};
            ob_view[i].limit_lo = s_q.ob[i].limit_lo;
            ob_view[i].tgt      = {s_q.ob[i].tgt_hi, s_q.ob[i].tgt_lo};
            ob_view[i].kind     = s_q.ob[i].kind;
            ob_view[i].en       = s_q.ob[i].en;
            ib_view[i].tgt      = {s_q.ib[i].tgt_hi, s_q.ib[i].tgt_lo};
            ib_view[i].en       = s_q.ib[i].en;
            ib_view[i].bar_mode = s_q.ib[i].bar_mode;
            ib_view[i].bar      = s_q.ib[i].bar;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/xw_ob_match.sv
module xw_ob_match
    import xw_pkg::*;
#(
    parameter int N_WIN = 4
) (
    input  xw_ob_view_t [N_WIN-1:0] win,
    input  logic [63:0]             addr,
    output logic [63:0]             bus_addr,
    output logic [4:0]              kind,
    output logic                    hit
);
    logic [N_WIN-1:0] hit_v;
    logic [63:0]      xl_v [N_WIN];

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        always_comb begin
            hit_v[g] = win[g].en
                    && (addr[63:32] == win[g].base[63:32])
                    && (addr[31:0]  >= win[g].base[31:0])
                    && (addr[31:0]  <= win[g].limit_lo);
            xl_v[g]  = win[g].tgt + (addr - win[g].base);
        end
    end

    // scan from the top so the lowest hitting index is left standing
    always_comb begin
        bus_addr = addr;
        kind     = XW_MEM;
        hit      = 1'b0;
        for (int i = N_WIN - 1; i >= 0; i--) begin
            if (hit_v[i]) begin
                bus_addr = xl_v[i];
                kind     = win[i].kind;
                hit      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/xw_ib_map.sv
module xw_ib_map
    import xw_pkg::*;
#(
    parameter int N_WIN    = 4,
    parameter int IB_OFS_W = 32
) (
    input  xw_ib_view_t [N_WIN-1:0] win,
    input  logic [2:0]              bar,
    input  logic [IB_OFS_W-1:0]     offset,
    output logic [63:0]             local_addr,
    output logic                    hit
);
    logic [N_WIN-1:0] hit_v;
    logic [63:0]      ofs_ext;

    assign ofs_ext = 64'(offset);

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        assign hit_v[g] = win[g].en && win[g].bar_mode && (win[g].bar == bar);
    end

    always_comb begin
        local_addr = '0;
        hit        = 1'b0;
        for (int i = N_WIN - 1; i >= 0; i--) begin
            if (hit_v[i]) begin
                local_addr = win[i].tgt + ofs_ext;
                hit        = 1'b1;
            end
        end
    end

endmodule

// File: rtl/xlat_window_unit.sv
module xlat_window_unit
    import xw_pkg::*;
#(
    parameter int N_WIN    = 4,
    parameter int IB_OFS_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [11:0]         cfg_ofs,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    input  logic [63:0]         out_addr,
    output logic [63:0]         out_bus_addr,
    output logic [4:0]          out_kind,
    output logic                out_hit,
    input  logic [2:0]          in_bar,
    input  logic [IB_OFS_W-1:0] in_offset,
    output logic [63:0]         in_local_addr,
    output logic                in_hit
);
    xw_ob_view_t [N_WIN-1:0] ob_view;
    xw_ib_view_t [N_WIN-1:0] ib_view;

    xw_window_regs #(.N_WIN(N_WIN)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_ofs   (cfg_ofs),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ob_view   (ob_view),
        .ib_view   (ib_view)
    );

    xw_ob_match #(.N_WIN(N_WIN)) i_ob (
        .win      (ob_view),
        .addr     (out_addr),
        .bus_addr (out_bus_addr),
        .kind     (out_kind),
        .hit      (out_hit)
    );

    xw_ib_map #(.N_WIN(N_WIN), .IB_OFS_W(IB_OFS_W)) i_ib (
        .win        (ib_view),
        .bar        (in_bar),
        .offset     (in_offset),
        .local_addr (in_local_addr),
        .hit        (in_hit)
    );

endmodule

// File: rtl/xw_checker.sv
module xw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [11:0] cfg_ofs,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic [63:0] out_addr,
    input logic [63:0] out_bus_addr,
    input logic [4:0]  out_kind,
    input logic        out_hit,
    input logic [63:0] in_local_addr,
    input logic        in_hit
);
    assert_miss_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_hit |-> (out_bus_addr == out_addr) && (out_kind == 5'd0));

    assert_view_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_ofs == 12'h900) ##1 (!cfg_we && cfg_ofs == 12'h900)
        |-> cfg_rdata == $past(cfg_wdata));

    assert_in_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_hit |-> in_local_addr == 64'd0);

    assert_hold_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we ##1 $stable(out_addr)
        |-> $stable(out_bus_addr) && $stable(out_hit) && $stable(out_kind));

endmodule

bind xlat_window_unit xw_checker i_xw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_ofs       (cfg_ofs),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .out_addr      (out_addr),
    .out_bus_addr  (out_bus_addr),
    .out_kind      (out_kind),
    .out_hit       (out_hit),
    .in_local_addr (in_local_addr),
    .in_hit        (in_hit)
);

// File: tb/test_xlat_window_unit.sv
`timescale 1ns/1ps
module test_xlat_window_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_ofs = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [63:0] out_addr = '0;
    logic [63:0] out_bus_addr;
    logic [4:0]  out_kind;
    logic        out_hit;
    logic [2:0]  in_bar = '0;
    logic [31:0] in_offset = '0;
    logic [63:0] in_local_addr;
    logic        in_hit;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    xlat_window_unit i_xlat_window_unit (.*);

    typedef struct {
        int          kind;   // 0 register read, 1 outgoing, 2 incoming
        logic [63:0] exp_a;
        logic [4:0]  exp_k;
        logic        exp_h;
        string       tag;
    } item_t;

    item_t q[$];
    item_t it;

    // monitor: compare every queued expectation away from the clock edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            it = q.pop_front();
            checks++;
            if (it.kind == 0) begin
                if (cfg_rdata !== it.exp_a[31:0]) begin
                    fails++;
                    $display("FAIL %s: rdata %h expected %h", it.tag, cfg_rdata, it.exp_a[31:0]);
                end
            end else if (it.kind == 1) begin
                if (out_bus_addr !== it.exp_a || out_kind !== it.exp_k || out_hit !== it.exp_h) begin
                    fails++;
                    $display("FAIL %s: out %h/%0d/%b expected %h/%0d/%b", it.tag,
                             out_bus_addr, out_kind, out_hit, it.exp_a, it.exp_k, it.exp_h);
                end
            end else begin
                if (in_local_addr !== it.exp_a || in_hit !== it.exp_h) begin
                    fails++;
                    $display("FAIL %s: in %h/%b expected %h/%b", it.tag,
                             in_local_addr, in_hit, it.exp_a, it.exp_h);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] o, input logic [31:0] d);
        cfg_we = 1'b1; cfg_ofs = o; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] o, input logic [31:0] e, input string tag);
        item_t x;
        cfg_ofs = o;
        x.kind = 0; x.exp_a = {32'd0, e}; x.exp_k = '0; x.exp_h = 1'b0; x.tag = tag;
        q.push_back(x);
        @(posedge clk); #1;
    endtask

    task automatic ob_chk(input logic [63:0] a, input logic [63:0] e, input logic [4:0] k,
                          input logic h, input string tag);
        item_t x;
        out_addr = a;
        x.kind = 1; x.exp_a = e; x.exp_k = k; x.exp_h = h; x.tag = tag;
        q.push_back(x);
        @(posedge clk); #1;
    endtask

    task automatic ob_miss(input logic [63:0] a, input string tag);
        ob_chk(a, a, 5'd0, 1'b0, tag);
    endtask

    task automatic ib_chk(input logic [2:0] b, input logic [31:0] o, input logic [63:0] e,
                          input logic h, input string tag);
        item_t x;
        in_bar = b; in_offset = o;
        x.kind = 2; x.exp_a = e; x.exp_k = '0; x.exp_h = h; x.tag = tag;
        q.push_back(x);
        @(posedge clk); #1;
    endtask

    task automatic prog_ob(input logic [1:0] idx, input logic [31:0] bl, input logic [31:0] bh,
                           input logic [31:0] lim, input logic [31:0] tl, input logic [31:0] th,
                           input logic [4:0] k, input logic [31:0] ctrl);
        wr(12'h900, {30'd0, idx});
        wr(12'h90C, bl);  wr(12'h910, bh); wr(12'h914, lim);
        wr(12'h918, tl);  wr(12'h91C, th); wr(12'h904, {27'd0, k});
        wr(12'h908, ctrl);
    endtask

    task automatic prog_ib(input logic [1:0] idx, input logic [31:0] tl, input logic [31:0] th,
                           input logic [31:0] ctrl);
        wr(12'h900, {1'b1, 29'd0, idx});
        wr(12'h918, tl); wr(12'h91C, th); wr(12'h908, ctrl);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        rd_chk(12'h900, 32'h0, "R1 selector");
        rd_chk(12'h908, 32'h0, "R1 control");
        rd_chk(12'h914, 32'h0, "R1 limit");
        ob_miss(64'h0000_0000_1000_0010, "R1 no window");
        ib_chk(3'd0, 32'h10, 64'd0, 1'b0, "R1 no incoming");

        // outgoing windows
        prog_ob(2'd0, 32'h1000_0000, 32'h0, 32'h1000_FFFF, 32'h8000_0000, 32'h1, 5'd0, 32'h8000_0000);
        prog_ob(2'd1, 32'h1000_8000, 32'h0, 32'h1001_7FFF, 32'h0000_2000, 32'h0, 5'd2, 32'h8000_0000);
        prog_ob(2'd2, 32'h2000_0000, 32'h5, 32'h2000_0FFF, 32'h033A_0000, 32'h0, 5'd4, 32'h8000_0000);
        prog_ob(2'd3, 32'h3000_0000, 32'h0, 32'h3000_0FFF, 32'h0, 32'h0, 5'd5, 32'h0);

        // R2 / R3 readback
        rd_chk(12'h900, 32'h3, "R2 selector readback");
        rd_chk(12'h904, 32'h5, "R3 kind of window 3");
        wr(12'h900, 32'h2);
        rd_chk(12'h904, 32'h4, "R3 kind of window 2");
        rd_chk(12'h918, 32'h033A_0000, "R3 target low of window 2");
        rd_chk(12'h910, 32'h5, "R3 base high of window 2");
        rd_chk(12'h908, 32'h8000_0000, "R3 control of window 2");
        wr(12'h920, 32'hDEAD_BEEF);
        rd_chk(12'h920, 32'h0, "R3 unmapped offset reads zero");
        rd_chk(12'h90C, 32'h2000_0000, "R3 unmapped write ignored");

        // R4 R5 R6 outgoing lookup
        ob_chk(64'h0000_0000_1000_0010, 64'h0000_0001_8000_0010, 5'd0, 1'b1, "R4 inside window 0");
        ob_chk(64'h0000_0000_1000_9000, 64'h0000_0001_8000_9000, 5'd0, 1'b1, "R6 overlap lowest index");
        ob_chk(64'h0000_0000_1001_0000, 64'h0000_0000_0000_A000, 5'd2, 1'b1, "R4 window 1 only");
        ob_chk(64'h0000_0000_1001_7FFF, 64'h0000_0000_0001_1FFF, 5'd2, 1'b1, "R5 at limit");
        ob_miss(64'h0000_0000_1001_8000, "R5 limit plus one");
        ob_miss(64'h0000_0000_0FFF_FFFF, "R5 base minus one");
        ob_miss(64'h0000_0000_2000_0000, "R4 high word mismatch");
        ob_chk(64'h0000_0005_2000_0000, 64'h0000_0000_033A_0000, 5'd4, 1'b1, "R11 config fields");
        ob_miss(64'h0000_0000_3000_0010, "R8 disabled window");
        ob_miss(64'h0000_0007_0000_0000, "R7 miss pass-through");

        wr(12'h900, 32'h3);
        wr(12'h908, 32'h8000_0000);
        ob_chk(64'h0000_0000_3000_0010, 64'h0000_0000_0000_0010, 5'd5, 1'b1, "R8 enabled after write");

        // incoming windows
        prog_ib(2'd0, 32'h4000_0000, 32'h0, 32'hC000_0100);
        prog_ib(2'd1, 32'h6000_0000, 32'h0, 32'h8000_0400);
        prog_ib(2'd2, 32'h5000_0000, 32'h2, 32'hC000_0100);
        prog_ib(2'd3, 32'h7000_0000, 32'h0, 32'hC000_0400);

        ib_chk(3'd1, 32'h123, 64'h0000_0000_4000_0123, 1'b1, "R9 BAR 1 lowest index");
        ib_chk(3'd4, 32'h10,  64'h0000_0000_7000_0010, 1'b1, "R9 BAR-match bit required");
        ib_chk(3'd2, 32'h10,  64'd0, 1'b0, "R9 no window for BAR");
        rd_chk(12'h900, 32'h8000_0003, "R2 incoming selector readback");
        rd_chk(12'h918, 32'h7000_0000, "R3 incoming target low");

        // R10 banks independent
        wr(12'h900, 32'h0);
        rd_chk(12'h918, 32'h8000_0000, "R10 outgoing target kept");
        rd_chk(12'h908, 32'h8000_0000, "R10 outgoing control kept");
        ob_chk(64'h0000_0000_1000_0010, 64'h0000_0001_8000_0010, 5'd0, 1'b1, "R10 outgoing lookup kept");

        @(posedge clk); #1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule